// File: doc/BRIEF.md
# Waveform Packet Write Decoder

This block sits between a host link that delivers 16-bit words and the bus that fills a segmented sample memory shared by several output channels. It recognises a framed data package and takes from its header the number of payload packets, the target channel and the target segment. It then unpacks the payload into 18-bit sub-words (a 16-bit sample code plus two steering bits) and turns every sample into two byte-wide write beats that go to one channel at a time, at addresses that start at the base of the chosen segment.

The memory is organised as `NUM_SEG` segments of `SEG_DEPTH` samples. Writing may run on past the end of a segment into the next one, but stops at the last memory address. Each pair of channels shares one memory card: the card index and the half-word select come from the channel number. Framing faults (a stray word where a package should start, an out-of-range channel or segment, a missing end marker) raise a sticky error flag and send the block back to searching for the next package.

Top module: `wpkt_decoder`

## Requirements
- R1: After reset `in_ready` is 1, `wr_lo` and `wr_hi` are 0 and `err` is 0.
- R2: A package is, word by word: start marker 16'hA5C3, packet count N, channel number, segment number, ceil(9N/2) payload words, end marker 16'h5A3C; a well-formed package leaves `err` unchanged and produces exactly 4N samples (fewer only under R6).
- R3: Payload bytes are taken high byte first from each word; every 9 bytes form one packet whose first byte is most significant; the packet splits into four 18-bit sub-words, most significant first, each holding steering bits in [17:16] and the sample code in [15:0]; when N is odd the low byte of the last payload word is ignored.
- R4: Each sample is written as a low-byte beat (`wr_lo`, code bits [7:0]) followed in the next cycle by a high-byte beat (`wr_hi`, code bits [15:8], steering on `wr_steer`) at the same address; the two strobes are never high together.
- R5: The first sample of a package goes to address segment × `SEG_DEPTH`; each later sample goes to the previous address plus one, crossing segment borders.
- R6: Once the last memory address (`NUM_SEG`×`SEG_DEPTH`−1) has been written, the remaining samples of that package produce no strobes; the next package starts afresh at its own segment base.
- R7: During a package every beat carries `wr_card` = channel / 2 and `wr_half` = channel mod 2.
- R8: A channel number ≥ `NUM_CH` or a segment number ≥ `NUM_SEG` sets `err`, produces no writes and returns the block to start-marker search.
- R9: Any word other than the start marker received while searching sets `err` and is otherwise ignored; a following well-formed package is written normally.
- R10: A word other than the end marker in the end position (a length mismatch) sets `err`; `err` stays set until reset, and the following package is still decoded.
- R11: While payload bytes of an accepted word are still pending, `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Host word present |
| in_word | input | 16 | Host word |
| in_ready | output | 1 | Word taken on a cycle where `in_valid` is also high |
| wr_byte | output | 8 | Write data byte |
| wr_steer | output | 2 | Steering bits, meaningful with `wr_hi` |
| wr_lo | output | 1 | Strobe for the low code byte |
| wr_hi | output | 1 | Strobe for the high code byte and steering bits |
| wr_card | output | CARD_W | Memory card index (channel / 2) |
| wr_half | output | 1 | Sub-word select (channel mod 2) |
| wr_addr | output | ADDR_W | Sample address in the memory |
| err | output | 1 | Sticky framing error |

## Verification
The assertions watch the beat discipline on every cycle: the low beat always followed by a high beat at the same address, never both strobes at once, one-step address advance after each sample, silence after the last address, a card index inside the channel range, and a sticky error. What the assertions cannot see is whether the bytes on the bus are the right ones: the unpacking order, the odd-count padding byte, the segment base, the channel mapping and the error handling for each kind of framing fault are shown only by the bench, which sweeps every channel of a small configuration and compares each beat to a model of the package it sent.

// File: rtl/wpkt_pkg.sv
package wpkt_pkg;

    localparam int WORD_W        = 16;
    localparam int BYTE_W        = 8;
    localparam int CODE_W        = 16;
    localparam int STEER_W       = 2;
    localparam int SUB_W         = CODE_W + STEER_W;
    localparam int SUBS_PER_PKT  = 4;
    localparam int BYTES_PER_PKT = 9;
    localparam int PKT_BITS      = BYTES_PER_PKT * BYTE_W;

    typedef enum logic [2:0] {
        PH_HUNT,
        PH_COUNT,
        PH_CHAN,
        PH_SEG,
        PH_BODY,
        PH_CLOSE
    } phase_t;

    typedef struct packed {
        logic [STEER_W-1:0] steer;
        logic [CODE_W-1:0]  code;
    } sample_t;

    // Sub-word idx of a packet, idx 0 being the most significant.
    function automatic sample_t pick_sample(input logic [PKT_BITS-1:0] pkt,
                                            input int unsigned idx);
        logic [PKT_BITS-1:0] sh;
        sh = pkt >> (SUB_W * (SUBS_PER_PKT - 1 - idx));
        return sample_t'(sh[SUB_W-1:0]);
    endfunction

endpackage

// File: rtl/wpkt_byte_split.sv
module wpkt_byte_split
    import wpkt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    input  logic              single,
    input  logic              byte_take,
    output logic              empty,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] byte_data
);
    logic [WORD_W-1:0] word_q;
    logic              hi_q;
    logic              lo_q;

    assign empty      = !hi_q && !lo_q;
    assign byte_valid = hi_q || lo_q;
    assign byte_data  = hi_q ? word_q[WORD_W-1:BYTE_W] : word_q[BYTE_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            hi_q   <= 1'b0;
            lo_q   <= 1'b0;
        end else if (load) begin
            word_q <= word;
            hi_q   <= 1'b1;
            lo_q   <= !single;
        end else if (byte_take) begin
            if (hi_q) hi_q <= 1'b0;
            else      lo_q <= 1'b0;
        end
    end
endmodule

// File: rtl/wpkt_unpack.sv
module wpkt_unpack
    import wpkt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               byte_valid,
    input  logic [BYTE_W-1:0]  byte_data,
    output logic               byte_take,
    output logic               beat_valid,
    output logic               beat_hi,
    output logic [BYTE_W-1:0]  beat_byte,
    output logic [STEER_W-1:0] beat_steer,
    output logic               idle
);
    localparam int CNT_W  = $clog2(BYTES_PER_PKT);
    localparam int BEATS  = 2 * SUBS_PER_PKT;
    localparam int BEAT_W = $clog2(BEATS);

    logic [PKT_BITS-1:0] pkt_q;
    logic [CNT_W-1:0]    cnt_q;
    logic                emit_q;
    logic [BEAT_W-1:0]   beat_q;
    sample_t             cur;

    assign byte_take  = byte_valid && !emit_q;
    assign cur        = pick_sample(pkt_q, int'(beat_q[BEAT_W-1:1]));
    assign beat_valid = emit_q;
    assign beat_hi    = beat_q[0];
    assign beat_byte  = beat_q[0] ? cur.code[CODE_W-1:BYTE_W] : cur.code[BYTE_W-1:0];
    assign beat_steer = cur.steer;
    assign idle       = !emit_q && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            pkt_q  <= '0;
            cnt_q  <= '0;
            emit_q <= 1'b0;
            beat_q <= '0;
        end else if (byte_take) begin
            pkt_q <= {pkt_q[PKT_BITS-BYTE_W-1:0], byte_data};
            if (cnt_q == CNT_W'(BYTES_PER_PKT - 1)) begin
                cnt_q  <= '0;
                emit_q <= 1'b1;
                beat_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else if (emit_q) begin
            beat_q <= beat_q + 1'b1;
            if (beat_q == BEAT_W'(BEATS - 1)) emit_q <= 1'b0;
        end
    end
endmodule

// File: rtl/wpkt_addr_gen.sv
module wpkt_addr_gen #(
    parameter int SEG_DEPTH = 8192,
    parameter int NUM_SEG   = 16,
    localparam int DEPTH    = SEG_DEPTH * NUM_SEG,
    localparam int ADDR_W   = $clog2(DEPTH),
    localparam int OFF_W    = $clog2(SEG_DEPTH),
    localparam int SEG_W    = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [SEG_W-1:0]  seg,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              full
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
            full <= 1'b0;
        end else if (load) begin
            addr <= {seg, {OFF_W{1'b0}}};
            full <= 1'b0;
        end else if (step && !full) begin
            if (addr == LAST) full <= 1'b1;
            else              addr <= addr + 1'b1;
        end
    end
endmodule

// File: rtl/wpkt_decoder.sv
module wpkt_decoder
    import wpkt_pkg::*;
#(
    parameter int SEG_DEPTH              = 8192,
    parameter int NUM_SEG                = 16,
    parameter int NUM_CH                 = 24,
    parameter logic [WORD_W-1:0] START_W = 16'hA5C3,
    parameter logic [WORD_W-1:0] END_W   = 16'h5A3C,
    localparam int DEPTH                 = SEG_DEPTH * NUM_SEG,
    localparam int ADDR_W                = $clog2(DEPTH),
    localparam int SEG_W                 = ADDR_W - $clog2(SEG_DEPTH),
    localparam int CH_W                  = $clog2(NUM_CH),
    localparam int CARD_W                = (CH_W > 1) ? CH_W - 1 : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [WORD_W-1:0]  in_word,
    output logic               in_ready,
    output logic [BYTE_W-1:0]  wr_byte,
    output logic [STEER_W-1:0] wr_steer,
    output logic               wr_lo,
    output logic               wr_hi,
    output logic [CARD_W-1:0]  wr_card,
    output logic               wr_half,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic               err
);
    localparam int WC_W = WORD_W + 4;

    phase_t            ph_q;
    logic [WORD_W-1:0] cnt_q;
    logic [CH_W-1:0]   ch_q;
    logic [WC_W-1:0]   left_q;
    logic              err_q;

    logic              accept;
    logic [WC_W-1:0]   body_words;
    logic              ch_ok;
    logic              seg_ok;
    logic              seg_load;
    logic              split_load;
    logic              split_single;
    logic              split_empty;
    logic              byte_valid;
    logic [BYTE_W-1:0] byte_data;
    logic              byte_take;
    logic              beat_valid;
    logic              beat_hi;
    logic              unp_idle;
    logic              mem_full;

    assign accept       = in_valid && in_ready;
    assign body_words   = (WC_W'(cnt_q) * WC_W'(BYTES_PER_PKT) + WC_W'(1)) >> 1;
    assign ch_ok        = in_word < WORD_W'(NUM_CH);
    assign seg_ok       = in_word < WORD_W'(NUM_SEG);
    assign seg_load     = accept && (ph_q == PH_SEG) && seg_ok;
    assign split_load   = accept && (ph_q == PH_BODY);
    assign split_single = (left_q == WC_W'(1)) && cnt_q[0];

    always_comb begin
        case (ph_q)
            PH_BODY:  in_ready = split_empty;
            PH_CLOSE: in_ready = split_empty && unp_idle;
            default:  in_ready = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_HUNT;
            cnt_q  <= '0;
            ch_q   <= '0;
            left_q <= '0;
            err_q  <= 1'b0;
        end else if (accept) begin
            case (ph_q)
                PH_HUNT: begin
                    if (in_word == START_W) ph_q  <= PH_COUNT;
                    else                    err_q <= 1'b1;
                end
                PH_COUNT: begin
                    cnt_q <= in_word;
                    ph_q  <= PH_CHAN;
                end
                PH_CHAN: begin
                    if (ch_ok) begin
                        ch_q <= in_word[CH_W-1:0];
                        ph_q <= PH_SEG;
                    end else begin
                        err_q <= 1'b1;
                        ph_q  <= PH_HUNT;
                    end
                end
                PH_SEG: begin
                    if (seg_ok) begin
                        left_q <= body_words;
                        ph_q   <= (body_words == '0) ? PH_CLOSE : PH_BODY;
                    end else begin
                        err_q <= 1'b1;
                        ph_q  <= PH_HUNT;
                    end
                end
                PH_BODY: begin
                    left_q <= left_q - 1'b1;
                    if (left_q == WC_W'(1)) ph_q <= PH_CLOSE;
                end
                PH_CLOSE: begin
                    if (in_word != END_W) err_q <= 1'b1;
                    ph_q <= PH_HUNT;
                end
                default: ph_q <= PH_HUNT;
            endcase
        end
    end

    wpkt_byte_split u_split (
        .clk        (clk),
        .rst        (rst),
        .load       (split_load),
        .word       (in_word),
        .single     (split_single),
        .byte_take  (byte_take),
        .empty      (split_empty),
        .byte_valid (byte_valid),
        .byte_data  (byte_data)
    );

    wpkt_unpack u_unpack (
        .clk        (clk),
        .rst        (rst),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .byte_take  (byte_take),
        .beat_valid (beat_valid),
        .beat_hi    (beat_hi),
        .beat_byte  (wr_byte),
        .beat_steer (wr_steer),
        .idle       (unp_idle)
    );

    wpkt_addr_gen #(
        .SEG_DEPTH (SEG_DEPTH),
        .NUM_SEG   (NUM_SEG)
    ) u_addr (
        .clk  (clk),
        .rst  (rst),
        .load (seg_load),
        .seg  (in_word[SEG_W-1:0]),
        .step (wr_hi),
        .addr (wr_addr),
        .full (mem_full)
    );

    assign wr_lo   = beat_valid && !beat_hi && !mem_full;
    assign wr_hi   = beat_valid &&  beat_hi && !mem_full;
    assign wr_card = CARD_W'(ch_q >> 1);
    assign wr_half = ch_q[0];
    assign err     = err_q;

endmodule

// File: rtl/wpkt_decoder_chk.sv
module wpkt_decoder_chk #(
    parameter int ADDR_W = 17,
    parameter int CARD_W = 4,
    parameter int NUM_CH = 24,
    parameter int DEPTH  = 131072
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_lo,
    input logic              wr_hi,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [CARD_W-1:0] wr_card,
    input logic              wr_half,
    input logic              err
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (rst)
        !(wr_lo && wr_hi));

    assert_lo_then_hi_R4: assert property (@(posedge clk) disable iff (rst)
        wr_lo |=> (wr_hi && $stable(wr_addr)));

    assert_addr_step_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_hi && wr_addr != LAST) |=> (wr_addr == ADDR_W'($past(wr_addr) + 1'b1)));

    assert_stop_at_end_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_hi && wr_addr == LAST) |=> (!wr_lo && !wr_hi));

    assert_card_range_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_lo || wr_hi) |-> (int'({wr_card, wr_half}) < NUM_CH));

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

endmodule

bind wpkt_decoder wpkt_decoder_chk #(
    .ADDR_W (ADDR_W),
    .CARD_W (CARD_W),
    .NUM_CH (NUM_CH),
    .DEPTH  (DEPTH)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_lo   (wr_lo),
    .wr_hi   (wr_hi),
    .wr_addr (wr_addr),
    .wr_card (wr_card),
    .wr_half (wr_half),
    .err     (err)
);

// File: tb/wpkt_decoder_test.sv
module wpkt_decoder_test;
    localparam int SEG_DEPTH = 8;
    localparam int NUM_SEG   = 4;
    localparam int NUM_CH    = 6;
    localparam int DEPTH     = SEG_DEPTH * NUM_SEG;
    localparam int ADDR_W    = 5;
    localparam int CARD_W    = 2;
    localparam logic [15:0] SOP = 16'hA5C3;
    localparam logic [15:0] EOP = 16'h5A3C;
    localparam int MAXB = 1024;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [15:0]       in_word = '0;
    logic              in_ready;
    logic [7:0]        wr_byte;
    logic [1:0]        wr_steer;
    logic              wr_lo;
    logic              wr_hi;
    logic [CARD_W-1:0] wr_card;
    logic              wr_half;
    logic [ADDR_W-1:0] wr_addr;
    logic              err;

    int checks = 0;
    int errors = 0;
    int exp_n  = 0;
    int obs_n  = 0;

    logic        e_hi    [MAXB];
    logic [7:0]  e_byte  [MAXB];
    logic [1:0]  e_steer [MAXB];
    int          e_addr  [MAXB];
    int          e_ch    [MAXB];

    always #4 clk = ~clk;

    wpkt_decoder #(
        .SEG_DEPTH (SEG_DEPTH),
        .NUM_SEG   (NUM_SEG),
        .NUM_CH    (NUM_CH)
    ) uut (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_word  (in_word),
        .in_ready (in_ready),
        .wr_byte  (wr_byte),
        .wr_steer (wr_steer),
        .wr_lo    (wr_lo),
        .wr_hi    (wr_hi),
        .wr_card  (wr_card),
        .wr_half  (wr_half),
        .wr_addr  (wr_addr),
        .err      (err)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic logic [7:0] pb(input int p, input int i);
        return 8'((p * 53 + i * 29 + 7) & 255);
    endfunction

    task automatic add_beat(input logic hi, input logic [7:0] b, input logic [1:0] s,
                            input int a, input int ch);
        e_hi[exp_n] = hi; e_byte[exp_n] = b; e_steer[exp_n] = s;
        e_addr[exp_n] = a; e_ch[exp_n] = ch;
        exp_n++;
    endtask

    // Model of R3, R4, R5, R6, R7
    task automatic expect_pkg(input int p, input int ch, input int seg, input int npk);
        int s;
        s = 0;
        for (int k = 0; k < npk; k++) begin
            logic [71:0] v;
            v = '0;
            for (int b = 0; b < 9; b++) v = {v[63:0], pb(p, k * 9 + b)};
            for (int j = 0; j < 4; j++) begin
                logic [71:0] t;
                int a;
                t = v >> (18 * (3 - j));
                a = seg * SEG_DEPTH + s;
                s++;
                if (a < DEPTH) begin
                    add_beat(1'b0, t[7:0],  t[17:16], a, ch);
                    add_beat(1'b1, t[15:8], t[17:16], a, ch);
                end
            end
        end
    endtask

    // Called and returns at a falling edge.
    task automatic send_word(input logic [15:0] w);
        in_valid = 1'b1;
        in_word  = w;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_pkg(input int p, input int ch, input int seg, input int npk,
                            input logic [15:0] tail);
        int nb;
        nb = 9 * npk;
        send_word(SOP);
        send_word(16'(npk));
        send_word(16'(ch));
        send_word(16'(seg));
        for (int i = 0; i < nb; i += 2) begin
            send_word({pb(p, i), (i + 1 < nb) ? pb(p, i + 1) : 8'h00});
            if (i == 0) check(in_ready == 1'b0, "R11 ready low with bytes pending", int'(in_ready), 0);
        end
        send_word(tail);
    endtask

    task automatic settle_and_count(input string req);
        repeat (3) @(negedge clk);
        check(obs_n == exp_n, req, obs_n, exp_n);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    always @(negedge clk) begin
        if (!rst && (wr_lo || wr_hi)) begin
            if (obs_n >= exp_n) begin
                check(1'b0, "R6 write beyond expected set", int'(wr_addr), -1);
            end else begin
                check(wr_hi == e_hi[obs_n] && wr_byte == e_byte[obs_n]
                      && int'(wr_addr) == e_addr[obs_n]
                      && int'({wr_card, wr_half}) == e_ch[obs_n]
                      && (!wr_hi || wr_steer == e_steer[obs_n]),
                      "R3 R4 R5 R7 write beat",
                      int'({wr_hi, wr_steer, wr_byte, wr_card, wr_half, wr_addr}),
                      int'({e_hi[obs_n], e_hi[obs_n] ? e_steer[obs_n] : wr_steer, e_byte[obs_n],
                            CARD_W'(e_ch[obs_n] / 2), 1'(e_ch[obs_n] % 2), ADDR_W'(e_addr[obs_n])}));
            end
            obs_n++;
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
        check(!wr_lo && !wr_hi, "R1 strobes idle after reset", int'({wr_lo, wr_hi}), 0);
        check(err == 1'b0, "R1 err clear after reset", int'(err), 0);
        rst = 1'b0;
        @(negedge clk);

        // R2 R3 R7 sweep over every channel, odd and even packet counts
        for (int ch = 0; ch < NUM_CH; ch++) begin
            expect_pkg(ch, ch, ch % NUM_SEG, (ch % 2) + 1);
            send_pkg(ch, ch, ch % NUM_SEG, (ch % 2) + 1, EOP);
            settle_and_count("R2 sample count per package");
            check(err == 1'b0, "R2 err untouched by good package", int'(err), 0);
        end

        // R2 empty package
        send_pkg(20, 1, 0, 0, EOP);
        settle_and_count("R2 empty package writes nothing");
        check(err == 1'b0, "R2 empty package err", int'(err), 0);

        // R5 run across a segment border
        expect_pkg(21, 3, 1, 3);
        send_pkg(21, 3, 1, 3, EOP);
        settle_and_count("R5 writes across segment border");

        // R6 stop at the last address, then a fresh package restarts
        expect_pkg(22, 4, NUM_SEG - 1, 3);
        send_pkg(22, 4, NUM_SEG - 1, 3, EOP);
        settle_and_count("R6 writes limited to memory end");
        expect_pkg(23, 5, 0, 1);
        send_pkg(23, 5, 0, 1, EOP);
        settle_and_count("R6 next package restarts at base");
        check(err == 1'b0, "R6 overflow is not an error", int'(err), 0);

        // R8 channel out of range
        send_word(SOP); send_word(16'd1); send_word(16'(NUM_CH));
        settle_and_count("R8 bad channel writes nothing");
        check(err == 1'b1, "R8 bad channel sets err", int'(err), 1);

        // R8 segment out of range
        do_reset();
        send_word(SOP); send_word(16'd1); send_word(16'd2); send_word(16'(NUM_SEG));
        settle_and_count("R8 bad segment writes nothing");
        check(err == 1'b1, "R8 bad segment sets err", int'(err), 1);

        // R9 stray word while hunting, then recovery
        do_reset();
        check(err == 1'b0, "R1 err cleared by reset", int'(err), 0);
        send_word(16'h1234);
        repeat (2) @(negedge clk);
        check(err == 1'b1, "R9 stray word sets err", int'(err), 1);
        check(obs_n == exp_n, "R9 stray word writes nothing", obs_n, exp_n);
        expect_pkg(30, 2, 2, 2);
        send_pkg(30, 2, 2, 2, EOP);
        settle_and_count("R9 package after stray word decoded");

        // R10 length mismatch: wrong word at end position
        do_reset();
        expect_pkg(31, 1, 1, 1);
        send_pkg(31, 1, 1, 1, 16'hBEEF);
        settle_and_count("R10 writes before mismatch");
        check(err == 1'b1, "R10 mismatch sets err", int'(err), 1);
        expect_pkg(32, 0, 3, 1);
        send_pkg(32, 0, 3, 1, EOP);
        settle_and_count("R10 package after mismatch decoded");
        check(err == 1'b1, "R10 err stays set", int'(err), 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule